// File: doc/BRIEF.md
# Power-Mode Clock Gating Controller

This block produces the divided internal clocks of a small embedded processor from a reference clock. It drives three outputs. The first is a core-domain clock for the execution and bus logic. The second is a peripheral-domain clock. The third is an enable for the external oscillator. Software selects one of four power modes with a one-cycle write strobe. The same write carries a 3-bit prescale code. In the normal running mode both domains toggle at half the reference rate. In the reduced-speed mode a prescale divider slows both domains further. The sleep mode stops only the core domain. The deep-sleep mode stops every domain and turns the oscillator off.

A wake input brings the block out of either sleep mode. It returns to whichever running mode, normal or reduced-speed, was selected last. The prescale divider stays in force during sleep when the last running mode was reduced-speed. After deep sleep the oscillator enable comes back at once. The clocks stay gated for a programmable settle count. A requested mode change never cuts a clock period short. It waits for the end of the current divided period, and a clock always stops and restarts from its low level.

Top module: `pmc_clock_ctrl`

## Requirements
- R1: After reset the block is in the normal running mode: osc_en is 1 and both core_clk and periph_clk toggle with a period of 2 reference cycles.
- R2: With mode code 0 (normal running) both clocks have a period of 2 reference cycles, whatever prescale code was written with it.
- R3: With mode code 1 (reduced speed) and prescale code c, both clocks have a period of 2^(c+1) reference cycles. Code 7 acts as code 6, so the longest period is 128.
- R4: With mode code 2 (sleep), core_clk stays low and periph_clk keeps running. Its period is 2^(c+1) when the last running mode written was reduced speed, where c is the code written with the sleep request. Otherwise its period is 2.
- R5: With mode code 3 (deep sleep), osc_en is 0 and both clocks stay low. Mode writes made while in deep sleep are ignored.
- R6: A wake pulse during sleep returns the block to the last running mode written, using the most recently written prescale code. A wake pulse while running has no effect.
- R7: A wake pulse during deep sleep sets osc_en on the next edge. The clocks stay low until the settle count elapses, and core_clk first rises on the settle_len+2-th edge after osc_en rises.
- R8: A mode write takes effect only at the end of the current divided period. A clock that is high when the request arrives completes its high phase, and state changes happen only while the clocks are low.
- R9: core_clk is never high while periph_clk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | One-cycle strobe that captures mode_sel and psc_sel |
| mode_sel | input | 2 | 0 normal, 1 reduced speed, 2 sleep, 3 deep sleep |
| psc_sel | input | 3 | Prescale code c, divide by 2^c on top of the base divide-by-two |
| wake | input | 1 | Wake request (interrupt or non-maskable interrupt) |
| settle_len | input | 8 | Oscillator settle count in reference cycles |
| core_clk | output | 1 | Core-domain divided clock |
| periph_clk | output | 1 | Peripheral-domain divided clock |
| osc_en | output | 1 | Oscillator enable |

## Verification
A mode write can wait up to one full divided period, at most 128 reference cycles, before it takes effect. The bench therefore waits 300 cycles after each write before it measures anything. It measures clock periods as the number of falling-edge samples between two rising levels, so the phase at which the change lands does not matter. The wake-from-deep-sleep check counts cycles exactly: osc_en is expected one edge after wake, and core_clk's first high settle_len+2 samples later. The deferral check samples core_clk for 50 cycles right after a write made inside a 64-cycle high phase.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_ACT,
        ST_PSV,
        ST_IDL,
        ST_PDN,
        ST_STL
    } pmc_state_e;

    localparam logic [1:0] MODE_ACT = 2'd0;
    localparam logic [1:0] MODE_PSV = 2'd1;
    localparam logic [1:0] MODE_IDL = 2'd2;
    localparam logic [1:0] MODE_PDN = 2'd3;
endpackage

// File: rtl/pmc_divider.sv
module pmc_divider #(
    parameter int MAX_LOG = 6,
    localparam int CNT_W = MAX_LOG + 1,
    localparam int PSC_W = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] k,
    input  logic             hold,
    input  logic             core_run,
    input  logic             periph_run,
    output logic             boundary,
    output logic             core_clk,
    output logic             periph_clk
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             core;
        logic             periph;
    } div_t;

    div_t             r_d, r_q;
    logic [CNT_W-1:0] top;

    // last count of a divided period for the current exponent
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            top[i] = (i <= int'(k));
        end
    end

    assign boundary = !hold && (r_q.cnt == top);

    always_comb begin
        r_d = r_q;
        if (hold || boundary) r_d.cnt = '0;
        else                  r_d.cnt = r_q.cnt + 1'b1;
        r_d.core   = core_run   && r_d.cnt[k];
        r_d.periph = periph_run && r_d.cnt[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign core_clk   = r_q.core;
    assign periph_clk = r_q.periph;

    p_core_sub_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk |-> periph_clk);

    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !periph_clk);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int MAX_LOG = 6,
    parameter int SETTLE_W = 8,
    localparam int PSC_W = $clog2(MAX_LOG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [1:0]          mode_sel,
    input  logic [PSC_W-1:0]    psc_sel,
    input  logic                wake,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                boundary,
    output pmc_state_e          state,
    output logic [PSC_W-1:0]    k,
    output logic                hold,
    output logic                core_run,
    output logic                periph_run,
    output logic                osc_en
);
    typedef struct packed {
        pmc_state_e          state;
        logic                ret_save;
        logic [PSC_W-1:0]    psc;
        logic                pend;
        logic [1:0]          pend_mode;
        logic [PSC_W-1:0]    pend_psc;
        logic                wake_pend;
        logic [SETTLE_W-1:0] settle;
        logic                osc;
    } fsm_t;

    fsm_t             r_d, r_q;
    logic [PSC_W-1:0] psc_clamped;
    pmc_state_e       ret_state;
    pmc_state_e       req_state;

    assign psc_clamped = (psc_sel > PSC_W'(MAX_LOG)) ? PSC_W'(MAX_LOG) : psc_sel;
    assign ret_state   = r_q.ret_save ? ST_PSV : ST_ACT;

    always_comb begin
        case (r_q.pend_mode)
            MODE_ACT: req_state = ST_ACT;
            MODE_PSV: req_state = ST_PSV;
            MODE_IDL: req_state = ST_IDL;
            default:  req_state = ST_PDN;
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_ACT, ST_PSV, ST_IDL: begin
                if (r_q.state == ST_IDL && wake) r_d.wake_pend = 1'b1;
                if (boundary) begin
                    if (r_q.state == ST_IDL && (r_q.wake_pend || wake)) begin
                        r_d.state     = ret_state;
                        r_d.wake_pend = 1'b0;
                        r_d.pend      = 1'b0;
                    end else if (r_q.pend) begin
                        r_d.state = req_state;
                        r_d.psc   = r_q.pend_psc;
                        r_d.pend  = 1'b0;
                        if (r_q.pend_mode == MODE_ACT) r_d.ret_save = 1'b0;
                        if (r_q.pend_mode == MODE_PSV) r_d.ret_save = 1'b1;
                    end
                end
                if (mode_wr) begin
                    r_d.pend      = 1'b1;
                    r_d.pend_mode = mode_sel;
                    r_d.pend_psc  = psc_clamped;
                end
            end
            ST_PDN: begin
                r_d.pend = 1'b0;
                if (wake) begin
                    r_d.state  = ST_STL;
                    r_d.settle = '0;
                end
            end
            default: begin
                if (r_q.settle == settle_len) r_d.state  = ret_state;
                else                          r_d.settle = r_q.settle + 1'b1;
            end
        endcase
        r_d.osc = (r_d.state != ST_PDN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_ACT;
            r_q.osc   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state      = r_q.state;
    assign k          = (r_q.state == ST_PSV || (r_q.state == ST_IDL && r_q.ret_save))
                        ? r_q.psc : '0;
    assign hold       = (r_q.state == ST_PDN) || (r_q.state == ST_STL);
    assign core_run   = (r_q.state == ST_ACT) || (r_q.state == ST_PSV);
    assign periph_run = core_run || (r_q.state == ST_IDL);
    assign osc_en     = r_q.osc;

    p_psc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.psc <= PSC_W'(MAX_LOG));

    p_pd_ignores_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PDN && !wake) |=> (r_q.state == ST_PDN));
endmodule

// File: rtl/pmc_clock_ctrl.sv
module pmc_clock_ctrl
    import pmc_pkg::*;
#(
    parameter int MAX_LOG = 6,
    parameter int SETTLE_W = 8,
    localparam int PSC_W = $clog2(MAX_LOG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_wr,
    input  logic [1:0]          mode_sel,
    input  logic [PSC_W-1:0]    psc_sel,
    input  logic                wake,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                core_clk,
    output logic                periph_clk,
    output logic                osc_en
);
    pmc_state_e       state;
    logic [PSC_W-1:0] k;
    logic             hold, core_run, periph_run, boundary;

    pmc_mode_fsm #(.MAX_LOG(MAX_LOG), .SETTLE_W(SETTLE_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_sel   (mode_sel),
        .psc_sel    (psc_sel),
        .wake       (wake),
        .settle_len (settle_len),
        .boundary   (boundary),
        .state      (state),
        .k          (k),
        .hold       (hold),
        .core_run   (core_run),
        .periph_run (periph_run),
        .osc_en     (osc_en)
    );

    pmc_divider #(.MAX_LOG(MAX_LOG)) i_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .k          (k),
        .hold       (hold),
        .core_run   (core_run),
        .periph_run (periph_run),
        .boundary   (boundary),
        .core_clk   (core_clk),
        .periph_clk (periph_clk)
    );

    p_pd_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDN) |-> (!osc_en && !periph_clk));

    p_settle_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STL) |-> (osc_en && !periph_clk && !core_clk));

    p_switch_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state) |-> (!periph_clk && !core_clk));

    p_idle_core_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDL && $past(state) == ST_IDL) |-> !core_clk);
endmodule

// File: tb/test_pmc_clock_ctrl.sv
module test_pmc_clock_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [2:0] psc_sel = 3'd0;
    logic       wake = 1'b0;
    logic [7:0] settle_len = 8'd5;
    logic       core_clk, periph_clk, osc_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmc_clock_ctrl i_pmc_clock_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_sel   (mode_sel),
        .psc_sel    (psc_sel),
        .wake       (wake),
        .settle_len (settle_len),
        .core_clk   (core_clk),
        .periph_clk (periph_clk),
        .osc_en     (osc_en)
    );

    // {mode, code, core period, periph period}
    localparam logic [20:0] VEC [8] = '{
        {2'd1, 3'd0, 8'd2,   8'd2},   // R3
        {2'd1, 3'd2, 8'd8,   8'd8},   // R3
        {2'd0, 3'd5, 8'd2,   8'd2},   // R2
        {2'd2, 3'd5, 8'd0,   8'd2},   // R4 after normal running
        {2'd1, 3'd6, 8'd128, 8'd128}, // R3
        {2'd1, 3'd7, 8'd128, 8'd128}, // R3 clamp
        {2'd2, 3'd1, 8'd0,   8'd4},   // R4 after reduced speed
        {2'd1, 3'd3, 8'd16,  8'd16}   // R3
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_mode(input logic [1:0] m, input logic [2:0] c);
        @(negedge clk);
        mode_sel = m;
        psc_sel  = c;
        mode_wr  = 1'b1;
        @(negedge clk);
        mode_wr  = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
    endtask

    // period in samples between two rising levels; 0 if the clock never rises
    task automatic measure(input bit use_core, output int per);
        bit prev, cur;
        int n;
        per = 0;
        n = 0;
        prev = use_core ? core_clk : periph_clk;
        while (n < 300) begin
            @(negedge clk);
            n++;
            cur = use_core ? core_clk : periph_clk;
            if (cur && !prev) break;
            prev = cur;
        end
        if (n < 300) begin
            n = 0;
            prev = 1'b1;
            while (n < 300) begin
                @(negedge clk);
                n++;
                cur = use_core ? core_clk : periph_clk;
                if (cur && !prev) break;
                prev = cur;
            end
            if (n < 300) per = n;
        end
    endtask

    initial begin
        int p, n;
        cycles(4);
        rst_n = 1'b1;
        cycles(3);

        // R1 reset state
        check("R1 osc_en", int'(osc_en), 1);
        measure(1'b1, p); check("R1 core period", p, 2);
        measure(1'b0, p); check("R1 periph period", p, 2);

        // vector walk: R2 R3 R4
        foreach (VEC[i]) begin
            write_mode(VEC[i][20:19], VEC[i][18:16]);
            cycles(300);
            measure(1'b1, p); check($sformatf("R2/R3/R4 vec%0d core", i), p, int'(VEC[i][15:8]));
            measure(1'b0, p); check($sformatf("R2/R3/R4 vec%0d periph", i), p, int'(VEC[i][7:0]));
        end

        // R6 wake from sleep returns to reduced speed (code 3 written with sleep)
        write_mode(2'd2, 3'd3);
        cycles(300);
        measure(1'b1, p); check("R6 sleeping core", p, 0);
        pulse_wake();
        cycles(200);
        measure(1'b1, p); check("R6 core after wake", p, 16);
        pulse_wake();
        cycles(50);
        measure(1'b1, p); check("R6 wake while running ignored", p, 16);

        // R8 request inside a 64-cycle high phase is deferred
        write_mode(2'd1, 3'd6);
        cycles(300);
        n = 0;
        while (!core_clk && n < 300) begin @(negedge clk); n++; end
        cycles(3);
        write_mode(2'd0, 3'd0);
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (core_clk) n++;
        end
        check("R8 high phase kept", n, 50);
        cycles(200);
        measure(1'b1, p); check("R8 new period after boundary", p, 2);

        // R5 deep sleep, writes ignored
        write_mode(2'd3, 3'd0);
        cycles(300);
        check("R5 osc_en off", int'(osc_en), 0);
        measure(1'b0, p); check("R5 periph stopped", p, 0);
        write_mode(2'd0, 3'd0);
        cycles(300);
        check("R5 write ignored osc_en", int'(osc_en), 0);
        measure(1'b0, p); check("R5 write ignored periph", p, 0);

        // R7 wake from deep sleep with settle count 5
        settle_len = 8'd5;
        pulse_wake();
        check("R7 osc_en back", int'(osc_en), 1);
        check("R7 core gated", int'(core_clk), 0);
        n = 0;
        while (!core_clk && n < 100) begin @(negedge clk); n++; end
        check("R7 first rise settle 5", n, 7);

        // R7 again with settle count 2
        write_mode(2'd3, 3'd0);
        cycles(300);
        settle_len = 8'd2;
        pulse_wake();
        n = 0;
        while (!core_clk && n < 100) begin @(negedge clk); n++; end
        check("R7 first rise settle 2", n, 4);
        measure(1'b1, p); check("R7 resumes normal period", p, 2);

        // R9 core never high while periph low, sleep entry and exit
        write_mode(2'd2, 3'd0);
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (core_clk && !periph_clk) n++;
        end
        check("R9 core within periph", n, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule